// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps a device in reset after a power-on, brown-out or external reset event until its supply and clock can be trusted, and then lets it run. After the reset inputs go low, it steps through up to three timed phases. The first is a power-up delay, counted in pulses of a slow reference tick. The second is an oscillator settling count, which counts rising edges of the raw oscillator signal. The third is a short extra delay that lets a PLL lock. Which phases run depends on a power-up-timer enable bit, on the oscillator mode and on whether the latest restart came from a supply event. A new reset event at any point sends the sequence back to its start.

Everything runs in one fast system clock domain. The reference tick arrives as a one-cycle strobe. The oscillator signal is asynchronous, so it passes through a two-flop synchronizer before its edges are counted. A sticky flag for each reset cause records what happened until a clear strobe removes it.

Top module: `pwrup_seq`

## Requirements
- R1: `reset_hold_o` is 1 from `rst_ni` and in every phase before RUN. It is 0 only when `phase_o` is RUN (4). The phase codes are IDLE=0, DELAY=1, OSC=2, PLL=3, RUN=4.
- R2: While any of `por_i`, `bor_i` or `ext_rst_i` is 1, `phase_o` is IDLE on the next cycle and stays there. This holds in every phase, including in the middle of a timed phase. When all three inputs are 0 again, the sequence restarts from its first applicable phase.
- R3: The DELAY phase runs when `pwrt_en_i` is 1 and a power-on or brown-out event has occurred since the last entry into RUN. It lasts exactly `DELAY_TICKS` pulses of `tick_i`. Otherwise the phase is skipped, so an external-only restart after RUN has no DELAY phase.
- R4: The OSC phase runs only in crystal modes: `osc_mode_i` 0 (low power), 1 (medium), 2 (high speed) or 3 (high speed with PLL). It ends on the `OSC_EDGES`-th rising edge of `osc_i`, counted after the synchronizer.
- R5: The PLL phase runs only in mode 3, directly after OSC. It lasts exactly `PLL_TICKS` tick pulses, whatever the value of `pwrt_en_i`.
- R6: Modes 4 to 7 (RC and external clock) skip OSC and PLL. They go to RUN straight after DELAY, or straight after IDLE if DELAY is skipped.
- R7: `por_flag_o`, `bor_flag_o` and `ext_flag_o` are set while their input is 1 and hold until `flag_clr_i` is 1. If an input is 1 in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; counts as a supply event |
| tick_i | input | 1 | One-cycle strobe from the slow reference oscillator |
| osc_i | input | 1 | Raw oscillator signal, asynchronous |
| por_i | input | 1 | Power-on reset event, level |
| bor_i | input | 1 | Brown-out reset event, level |
| ext_rst_i | input | 1 | External reset event, level |
| pwrt_en_i | input | 1 | Enables the power-up delay phase |
| osc_mode_i | input | 3 | Oscillator mode, 0..7 |
| flag_clr_i | input | 1 | Clears the sticky cause flags |
| reset_hold_o | output | 1 | Holds the device in reset while 1 |
| phase_o | output | 3 | Current phase code |
| por_flag_o | output | 1 | Sticky power-on cause flag |
| bor_flag_o | output | 1 | Sticky brown-out cause flag |
| ext_flag_o | output | 1 | Sticky external cause flag |

## Verification
The sequence is started with each cause under random oscillator modes and enable settings, and the tick strobe arrives after random gaps. The order of the phases and the tick count in each timed phase therefore show whether the mode decode, the enable gating and the supply-event memory are right. Directed aborts cut into the DELAY, OSC and PLL phases and then measure the restarted sequence. These cases tell a restart that keeps the pending supply event apart from one that drops it, and show whether stale counter state leaks into the new run. Flag tests cover the clear strobe on its own and a clear that arrives together with a live cause.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DELAY = 3'd1,
    PH_OSC   = 3'd2,
    PH_PLL   = 3'd3,
    PH_RUN   = 3'd4
  } phase_e;

  localparam logic [2:0] MODE_HSPLL = 3'd3;

  function automatic logic is_xtal(input logic [2:0] mode);
    return mode <= 3'd3;
  endfunction
endpackage

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + W'(1);
  end

  // R3
  tick_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < limit_i);
endmodule

// File: rtl/pwrup_edge_counter.sv
module pwrup_edge_counter #(
  parameter int unsigned EDGES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [2:0]    sync_q;  // [0],[1] synchronizer, [2] edge history
  logic          rise;
  logic [CW-1:0] cnt_q;

  assign rise   = sync_q[1] & ~sync_q[2];
  assign done_o = run_i && rise && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], osc_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (rise)   cnt_q <= done_o ? '0 : cnt_q + CW'(1);
  end

  // R4
  osc_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= LAST);
  // R4
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 72,
  parameter int unsigned PLL_TICKS   = 2,
  parameter int unsigned OSC_EDGES   = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       osc_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       ext_rst_i,
  input  logic       pwrt_en_i,
  input  logic [2:0] osc_mode_i,
  input  logic       flag_clr_i,
  output logic       reset_hold_o,
  output logic [2:0] phase_o,
  output logic       por_flag_o,
  output logic       bor_flag_o,
  output logic       ext_flag_o
);
  localparam int unsigned MAXT = (DELAY_TICKS > PLL_TICKS) ? DELAY_TICKS : PLL_TICKS;
  localparam int unsigned TW   = $clog2(MAXT + 1);
  localparam int unsigned NCAUSE = 3;

  phase_e        state_q, state_d;
  logic          supply_q;      // supply event pending since last RUN
  logic          hold_q;
  logic          any_rst;
  logic          tmr_run, tmr_done, osc_run, osc_done;
  logic [TW-1:0] tmr_limit;
  logic [NCAUSE-1:0] cause_in, flag_q;

  assign any_rst = por_i | bor_i | ext_rst_i;

  assign tmr_run   = (state_q == PH_DELAY) || (state_q == PH_PLL);
  assign tmr_limit = (state_q == PH_PLL) ? TW'(PLL_TICKS) : TW'(DELAY_TICKS);
  assign osc_run   = (state_q == PH_OSC);

  pwrup_tick_timer #(.W(TW)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (tmr_run),
    .tick_i  (tick_i),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  pwrup_edge_counter #(.EDGES(OSC_EDGES)) i_osc_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .osc_i  (osc_i),
    .run_i  (osc_run),
    .done_o (osc_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: begin
        if (supply_q && pwrt_en_i)  state_d = PH_DELAY;
        else if (is_xtal(osc_mode_i)) state_d = PH_OSC;
        else                          state_d = PH_RUN;
      end
      PH_DELAY: if (tmr_done) state_d = is_xtal(osc_mode_i) ? PH_OSC : PH_RUN;
      PH_OSC:   if (osc_done) state_d = (osc_mode_i == MODE_HSPLL) ? PH_PLL : PH_RUN;
      PH_PLL:   if (tmr_done) state_d = PH_RUN;
      PH_RUN:   state_d = PH_RUN;
      default:  state_d = PH_IDLE;
    endcase
    if (any_rst) state_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_IDLE;
      supply_q <= 1'b1;
      hold_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      hold_q   <= (state_d != PH_RUN);
      if (por_i || bor_i)                            supply_q <= 1'b1;
      else if (state_d == PH_RUN && state_q != PH_RUN) supply_q <= 1'b0;
    end
  end

  assign cause_in = {ext_rst_i, bor_i, por_i};

  for (genvar g = 0; g < NCAUSE; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q[g] <= 1'b0;
      else if (cause_in[g]) flag_q[g] <= 1'b1;
      else if (flag_clr_i)  flag_q[g] <= 1'b0;
    end
    // R7
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !flag_clr_i) |=> flag_q[g]);
  end

  assign reset_hold_o = hold_q;
  assign phase_o      = state_q;
  assign por_flag_o   = flag_q[0];
  assign bor_flag_o   = flag_q[1];
  assign ext_flag_o   = flag_q[2];

  // R1
  release_only_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_hold_o |-> state_q == PH_RUN);
  // R2
  restart_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst |=> state_q == PH_IDLE);
  // R3
  delay_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DELAY && $past(state_q) != PH_DELAY) |-> $past(pwrt_en_i));
  // R5
  pll_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_PLL && $past(state_q) != PH_PLL)
      |-> ($past(state_q) == PH_OSC && $past(osc_mode_i) == MODE_HSPLL));
endmodule

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
  localparam int DT = 72;
  localparam int PT = 2;
  localparam int OE = 32;
  localparam int OSC_HALF = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, osc_i = 1'b0;
  logic por_i = 1'b1, bor_i = 1'b0, ext_rst_i = 1'b0;
  logic pwrt_en_i = 1'b1, flag_clr_i = 1'b0;
  logic [2:0] osc_mode_i = 3'd1;
  logic reset_hold_o, por_flag_o, bor_flag_o, ext_flag_o;
  logic [2:0] phase_o;

  int checks = 0, failures = 0, cyc = 0;
  logic [2:0] ef; // expected flags {ext,bor,por}

  always #2.5 clk = ~clk;

  pwrup_seq #(.DELAY_TICKS(DT), .PLL_TICKS(PT), .OSC_EDGES(OE)) i_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .osc_i(osc_i),
    .por_i(por_i), .bor_i(bor_i), .ext_rst_i(ext_rst_i),
    .pwrt_en_i(pwrt_en_i), .osc_mode_i(osc_mode_i), .flag_clr_i(flag_clr_i),
    .reset_hold_o(reset_hold_o), .phase_o(phase_o),
    .por_flag_o(por_flag_o), .bor_flag_o(bor_flag_o), .ext_flag_o(ext_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hist(input logic [2:0] mode, input logic en, input bit pw);
    int h = 0;
    if (pw && en)     h = (h << 3) | 1;
    if (mode <= 3'd3) h = (h << 3) | 2;
    if (mode == 3'd3) h = (h << 3) | 3;
    h = (h << 3) | 4;
    return h;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    forever begin
      repeat (2 + $urandom % 6) @(posedge clk);
      #1 tick_i = 1'b1;
      @(posedge clk);
      #1 tick_i = 1'b0;
    end
  end

  initial forever begin
    repeat (OSC_HALF) @(posedge clk);
    #1 osc_i = ~osc_i;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // hold a cause for a few cycles; R2 checked while it is high
  task automatic pulse_cause(input int c);
    @(posedge clk); #1;
    case (c)
      0: por_i = 1'b1;
      1: bor_i = 1'b1;
      default: ext_rst_i = 1'b1;
    endcase
    ef[c] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase_o == 3'd0 && reset_hold_o, "R2 idle while cause high", phase_o, 0);
    @(posedge clk); #1;
    por_i = 1'b0; bor_i = 1'b0; ext_rst_i = 1'b0;
  endtask

  task automatic measure(input logic [2:0] mode, input logic en, input bit pw);
    int h = 0, dt = 0, pt = 0, oc = 0, guard = 0;
    logic [2:0] last = 3'd0;
    bit hold_bad = 0;
    while (guard < 20000) begin
      @(negedge clk);
      guard++;
      if (phase_o != last) begin
        h = (h << 3) | int'(phase_o);
        last = phase_o;
      end
      if (phase_o == 3'd1 && tick_i) dt++;
      if (phase_o == 3'd3 && tick_i) pt++;
      if (phase_o == 3'd2) oc++;
      if (phase_o != 3'd4 && !reset_hold_o) hold_bad = 1;
      if (phase_o == 3'd4) break;
    end
    chk(!hold_bad, "R1 hold during phases", hold_bad, 0);
    chk(phase_o == 3'd4 && !reset_hold_o, "R1 released in RUN", reset_hold_o, 0);
    chk(h == exp_hist(mode, en, pw), "R4/R6 phase order", h, exp_hist(mode, en, pw));
    chk(dt == ((pw && en) ? DT : 0), "R3 delay ticks", dt, (pw && en) ? DT : 0);
    chk(pt == ((mode == 3'd3) ? PT : 0), "R5 pll ticks", pt, (mode == 3'd3) ? PT : 0);
    if (mode <= 3'd3)
      chk(oc >= (OE - 1) * 2 * OSC_HALF && oc <= OE * 2 * OSC_HALF + 1, "R4 osc length", oc, OE * 2 * OSC_HALF);
    else
      chk(oc == 0, "R6 no osc phase", oc, 0);
  endtask

  task automatic run_seq(input int c, input logic [2:0] mode, input logic en);
    @(posedge clk); #1;
    osc_mode_i = mode; pwrt_en_i = en;
    pulse_cause(c);
    measure(mode, en, c != 2);
  endtask

  task automatic wait_phase(input logic [2:0] p, input int extra);
    int g = 0;
    do begin @(negedge clk); g++; end while (phase_o != p && g < 20000);
    repeat (extra) @(negedge clk);
  endtask

  task automatic chk_flags(input string req);
    @(negedge clk);
    chk({ext_flag_o, bor_flag_o, por_flag_o} == ef, req,
        {ext_flag_o, bor_flag_o, por_flag_o}, ef);
  endtask

  task automatic clear_flags();
    @(posedge clk); #1 flag_clr_i = 1'b1;
    @(posedge clk); #1 flag_clr_i = 1'b0;
    ef = '0;
  endtask

  initial begin
    ef = 3'b000;
    repeat (4) @(negedge clk);
    chk(reset_hold_o && phase_o == 3'd0, "R1 reset state", phase_o, 0);
    chk({ext_flag_o, bor_flag_o, por_flag_o} == 3'b000, "R7 flags at reset",
        {ext_flag_o, bor_flag_o, por_flag_o}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    ef[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase_o == 3'd0, "R2 idle under power-on", phase_o, 0);
    @(posedge clk); #1 por_i = 1'b0;
    measure(3'd1, 1'b1, 1'b1);
    chk_flags("R7 por flag set");
    clear_flags();
    chk_flags("R7 flags cleared");

    // directed: each mode group, both enables
    run_seq(0, 3'd3, 1'b1);
    run_seq(1, 3'd3, 1'b0);
    run_seq(2, 3'd2, 1'b1);   // R3: external only, no delay
    run_seq(0, 3'd5, 1'b1);
    run_seq(2, 3'd4, 1'b0);
    chk_flags("R7 flags accumulate");
    clear_flags();

    // R2 abort inside DELAY keeps the supply event pending
    @(posedge clk); #1 osc_mode_i = 3'd2; pwrt_en_i = 1'b1;
    pulse_cause(0);
    wait_phase(3'd1, 100);
    pulse_cause(2);
    measure(3'd2, 1'b1, 1'b1);

    // R2 abort inside OSC with brown-out
    @(posedge clk); #1 osc_mode_i = 3'd3;
    pulse_cause(2);
    wait_phase(3'd2, 50);
    pulse_cause(1);
    measure(3'd3, 1'b1, 1'b1);

    // R2 abort inside PLL
    pulse_cause(0);
    wait_phase(3'd3, 1);
    pulse_cause(2);
    measure(3'd3, 1'b1, 1'b1);
    chk_flags("R7 flags after aborts");

    // R7 clear together with live cause: set wins
    @(posedge clk); #1 bor_i = 1'b1; flag_clr_i = 1'b1;
    @(posedge clk); #1 bor_i = 1'b0; flag_clr_i = 1'b0;
    ef = 3'b010;
    chk_flags("R7 set wins over clear");
    measure(osc_mode_i, pwrt_en_i, 1'b1);

    // random sequences
    for (int i = 0; i < 10; i++) begin
      int c = $urandom % 3;
      logic [2:0] m = 3'($urandom % 8);
      logic e = 1'($urandom % 2);
      run_seq(c, m, e);
    end
    chk_flags("R7 flags after random");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule